// File: doc/BRIEF.md
# Integer Add/Subtract Unit with Fixed-Point Status Register

This block pairs a 64-bit integer adder/subtractor with the status register that records its carry and signed-overflow results. Each valid operation produces a 64-bit sum at once. On the next clock edge it updates the carry pair, the overflow pair, or both, as the per-operation enables choose. The carry and overflow flags each come as two bits: a full-width flag and a low-word flag. Both bits of a pair are written together. In 64-bit mode they hold independent values. In 32-bit mode they hold the same value.

A summary-overflow bit collects every overflow ever reported until software clears it. Software reaches the whole register through a write port and a read port. The write port also stores an 8-bit compare field and a 7-bit count field. The unit only holds these two fields and gives them no meaning. Subtraction is of the subtract-from kind: the result is b + NOT a + carry-in. The extended forms take their carry-in from the stored carry flag.

Top module: `fxu_status_unit`

## Requirements
- R1: The read value places the flags at these bit positions: summary overflow at bit 31, overflow at 30, carry at 29, low-word overflow at 19, low-word carry at 18, the compare field at 15:8 and the count field at 6:0. Every other bit reads zero, including bits 63:32. All of them are zero after reset.
- R2: A register write loads each of the five flags from its own bit position of `wr_data`, independently of the others. It also stores the compare field and the count field from the bit positions listed in R1.
- R3: `sum` shows a + b + cin when `op_sub` = 0, and b + NOT a + cin when `op_sub` = 1. cin is the stored carry flag when `op_use_ca` = 1, and `op_cin` otherwise.
- R4: On a carry update, the low-word carry takes the carry out of bit 31 of the operation, in both modes. In 64-bit mode (`mode64` = 1) the carry flag takes the carry out of bit 63.
- R5: In 32-bit mode (`mode64` = 0), a carry update writes the carry out of bit 31 to the carry flag, so the two carry flags are equal.
- R6: On an overflow update in 64-bit mode, the overflow flag records signed overflow of the 64-bit result and the low-word overflow flag records signed overflow of bits 31:0. The two may differ.
- R7: In 32-bit mode, an overflow update writes the low-word signed overflow to both overflow flags.
- R8: Summary overflow is sticky. Each overflow update ORs the new overflow flag into it, and only a register write can clear it.
- R9: A valid operation with `upd_ca` = 0 leaves both carry flags unchanged. With `upd_ov` = 0 it leaves both overflow flags and summary overflow unchanged. When `op_valid` = 0, no flag changes.
- R10: When a register write and a valid updating operation fall in the same cycle, the register write decides every field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An operation is present this cycle |
| op_a | input | 64 | Operand a (the operand inverted on subtract) |
| op_b | input | 64 | Operand b |
| op_sub | input | 1 | 1 selects b + NOT a + cin |
| op_cin | input | 1 | Carry-in for the non-extended forms |
| op_use_ca | input | 1 | 1 takes the carry-in from the stored carry flag |
| mode64 | input | 1 | 1 selects 64-bit mode, 0 selects 32-bit mode |
| upd_ca | input | 1 | The operation writes the carry pair |
| upd_ov | input | 1 | The operation writes the overflow pair and summary overflow |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write value |
| sum | output | 64 | Result of the operation |
| rd_data | output | 64 | Register read value |

## Verification
The assertions assume that `mode64`, `upd_ca` and `upd_ov` are steady for the whole cycle in which `op_valid` is high. They also assume that control inputs never carry X while the unit is out of reset. The bench meets both conditions by changing every input only at the falling clock edge. It never leaves an input undriven after reset.

Operands are chosen to reach each corner: carry out of bit 31 alone, carry out of bit 63 alone, overflow in the low word alone, overflow in the full width alone, and extended forms that chain the stored carry. A random phase follows. It mixes modes, enables and occasional writes that land in the same cycle as an operation.

// File: rtl/fxu_pkg.sv
package fxu_pkg;
  localparam int FX_DW      = 64;
  localparam int FX_HW      = 32;
  localparam int SO_POS     = 31;
  localparam int OV_POS     = 30;
  localparam int CA_POS     = 29;
  localparam int OV_LO_POS  = 19;
  localparam int CA_LO_POS  = 18;
  localparam int CMP_LSB    = 8;
  localparam int CMP_W      = 8;
  localparam int CNT_LSB    = 0;
  localparam int CNT_W      = 7;

  typedef struct packed {
    logic             so;
    logic             ov;
    logic             ca;
    logic             ov_lo;
    logic             ca_lo;
    logic [CMP_W-1:0] cmp;
    logic [CNT_W-1:0] cnt;
  } fx_flags_t;

  function automatic logic [FX_HW-1:0] pack_flags(input fx_flags_t f);
    logic [FX_HW-1:0] w;
    w = '0;
    w[SO_POS]    = f.so;
    w[OV_POS]    = f.ov;
    w[CA_POS]    = f.ca;
    w[OV_LO_POS] = f.ov_lo;
    w[CA_LO_POS] = f.ca_lo;
    w[CMP_LSB +: CMP_W] = f.cmp;
    w[CNT_LSB +: CNT_W] = f.cnt;
    return w;
  endfunction

  function automatic fx_flags_t unpack_flags(input logic [FX_HW-1:0] w);
    fx_flags_t f;
    f.so    = w[SO_POS];
    f.ov    = w[OV_POS];
    f.ca    = w[CA_POS];
    f.ov_lo = w[OV_LO_POS];
    f.ca_lo = w[CA_LO_POS];
    f.cmp   = w[CMP_LSB +: CMP_W];
    f.cnt   = w[CNT_LSB +: CNT_W];
    return f;
  endfunction
endpackage

// File: rtl/fxu_adder.sv
module fxu_adder #(
  parameter int DW = 64
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          sub,
  input  logic          cin,
  output logic [DW-1:0] res,
  output logic          co_full,
  output logic          co_half,
  output logic          ovf_full,
  output logic          ovf_half
);
  localparam int HW = DW / 2;

  // Full-width sum with carry out on top.
  function automatic logic [DW:0] wide_add(input logic [DW-1:0] x, input logic [DW-1:0] y,
                                           input logic c);
    return {1'b0, x} + {1'b0, y} + {{DW{1'b0}}, c};
  endfunction

  // Signed-overflow vector: a bit is set where both addends agree in sign and the result does not.
  function automatic logic [DW-1:0] ovf_vec(input logic [DW-1:0] x, input logic [DW-1:0] y,
                                            input logic [DW-1:0] r);
    return ~(x ^ y) & (r ^ y);
  endfunction

  logic [DW-1:0] addend;
  logic [DW:0]   total;
  logic [DW-1:0] ovec;

  always_comb begin
    addend   = sub ? ~a : a;
    total    = wide_add(addend, b, cin);
    res      = total[DW-1:0];
    co_full  = total[DW];
    // Carry into bit HW is recovered from the sum bit and both addend bits.
    co_half  = total[HW] ^ addend[HW] ^ b[HW];
    ovec     = ovf_vec(addend, b, total[DW-1:0]);
    ovf_full = ovec[DW-1];
    ovf_half = ovec[HW-1];
  end
endmodule

// File: rtl/fxu_flag_sel.sv
module fxu_flag_sel (
  input  logic mode64,
  input  logic co_full,
  input  logic co_half,
  input  logic ovf_full,
  input  logic ovf_half,
  output logic ca_new,
  output logic ca_lo_new,
  output logic ov_new,
  output logic ov_lo_new
);
  always_comb begin
    ca_lo_new = co_half;
    ov_lo_new = ovf_half;
    ca_new    = mode64 ? co_full  : co_half;
    ov_new    = mode64 ? ovf_full : ovf_half;
  end
endmodule

// File: rtl/fxu_flag_reg.sv
module fxu_flag_reg
  import fxu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic             upd_ca,
  input  logic             upd_ov,
  input  logic             ca_new,
  input  logic             ca_lo_new,
  input  logic             ov_new,
  input  logic             ov_lo_new,
  input  logic             wr_en,
  input  logic [FX_HW-1:0] wr_data,
  output fx_flags_t        flags
);
  // Named events for the assertions.
  logic ca_fire, ov_fire, wr_fire;
  fx_flags_t wr_flags;

  assign wr_fire  = wr_en;
  assign ca_fire  = op_valid & upd_ca & ~wr_en;
  assign ov_fire  = op_valid & upd_ov & ~wr_en;
  assign wr_flags = unpack_flags(wr_data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
    end else if (wr_fire) begin
      flags <= wr_flags;
    end else begin
      if (ca_fire) begin
        flags.ca    <= ca_new;
        flags.ca_lo <= ca_lo_new;
      end
      if (ov_fire) begin
        flags.ov    <= ov_new;
        flags.ov_lo <= ov_lo_new;
        flags.so    <= flags.so | ov_new;
      end
    end
  end

  // R10 / R2: a write decides every flag bit
  a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (flags.so == $past(wr_data[SO_POS])) && (flags.ov == $past(wr_data[OV_POS])) &&
              (flags.ca == $past(wr_data[CA_POS])) && (flags.ov_lo == $past(wr_data[OV_LO_POS])) &&
              (flags.ca_lo == $past(wr_data[CA_LO_POS])));

  // R8: summary overflow never drops without a write
  a_r8_so_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flags.so && !wr_en) |=> flags.so);

  // R8: an overflow update folds the new overflow into summary overflow
  a_r8_so_collects: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && upd_ov && !wr_en) |=> (flags.so == ($past(flags.so) | flags.ov)));

  // R9: carry pair holds without a carry update
  a_r9_ca_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !(op_valid && upd_ca)) |=> $stable({flags.ca, flags.ca_lo}));

  // R9: overflow pair and summary hold without an overflow update
  a_r9_ov_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !(op_valid && upd_ov)) |=> $stable({flags.so, flags.ov, flags.ov_lo}));
endmodule

// File: rtl/fxu_status_unit.sv
module fxu_status_unit
  import fxu_pkg::*;
#(
  parameter int DW = FX_DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [DW-1:0] op_a,
  input  logic [DW-1:0] op_b,
  input  logic          op_sub,
  input  logic          op_cin,
  input  logic          op_use_ca,
  input  logic          mode64,
  input  logic          upd_ca,
  input  logic          upd_ov,
  input  logic          wr_en,
  input  logic [FX_HW-1:0] wr_data,
  output logic [DW-1:0] sum,
  output logic [DW-1:0] rd_data
);
  localparam int PAD_W = DW - FX_HW;

  fx_flags_t flags;
  logic cin_eff;
  logic co_full, co_half, ovf_full, ovf_half;
  logic ca_new, ca_lo_new, ov_new, ov_lo_new;

  assign cin_eff = op_use_ca ? flags.ca : op_cin;

  fxu_adder #(.DW(DW)) u_add (
    .a(op_a), .b(op_b), .sub(op_sub), .cin(cin_eff), .res(sum),
    .co_full(co_full), .co_half(co_half), .ovf_full(ovf_full), .ovf_half(ovf_half)
  );

  fxu_flag_sel u_sel (
    .mode64(mode64), .co_full(co_full), .co_half(co_half),
    .ovf_full(ovf_full), .ovf_half(ovf_half),
    .ca_new(ca_new), .ca_lo_new(ca_lo_new), .ov_new(ov_new), .ov_lo_new(ov_lo_new)
  );

  fxu_flag_reg u_reg (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .upd_ca(upd_ca), .upd_ov(upd_ov),
    .ca_new(ca_new), .ca_lo_new(ca_lo_new), .ov_new(ov_new), .ov_lo_new(ov_lo_new),
    .wr_en(wr_en), .wr_data(wr_data), .flags(flags)
  );

  assign rd_data = {{PAD_W{1'b0}}, pack_flags(flags)};

  // R5: narrow-mode carry update leaves both carry flags equal
  a_r5_narrow_ca: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && upd_ca && !mode64 && !wr_en) |=> (rd_data[CA_POS] == rd_data[CA_LO_POS]));

  // R7: narrow-mode overflow update leaves both overflow flags equal
  a_r7_narrow_ov: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && upd_ov && !mode64 && !wr_en) |=> (rd_data[OV_POS] == rd_data[OV_LO_POS]));

  // R1: the upper half of the read value stays clear
  a_r1_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en) |-> (rd_data[DW-1:FX_HW] == '0));
endmodule

// File: tb/fxu_status_unit_tb.sv
module fxu_status_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 0, op_sub = 0, op_cin = 0, op_use_ca = 0, mode64 = 1;
  logic        upd_ca = 0, upd_ov = 0, wr_en = 0;
  logic [63:0] op_a = '0, op_b = '0;
  logic [31:0] wr_data = '0;
  logic [63:0] sum, rd_data;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // Reference state
  bit m_so, m_ov, m_ca, m_ov32, m_ca32;
  bit [7:0] m_cmp;
  bit [6:0] m_cnt;

  always #10 clk = ~clk;

  fxu_status_unit u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_a(op_a), .op_b(op_b),
    .op_sub(op_sub), .op_cin(op_cin), .op_use_ca(op_use_ca), .mode64(mode64),
    .upd_ca(upd_ca), .upd_ov(upd_ov), .wr_en(wr_en), .wr_data(wr_data),
    .sum(sum), .rd_data(rd_data)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] model_read();
    logic [63:0] v;
    v = 64'd0;
    v[31] = m_so; v[30] = m_ov; v[29] = m_ca; v[19] = m_ov32; v[18] = m_ca32;
    v[15:8] = m_cmp; v[6:0] = m_cnt;
    return v;
  endfunction

  task automatic step(input string tag, input bit v, input logic [63:0] a, input logic [63:0] b,
                      input bit sub, input bit cin, input bit useca, input bit m64,
                      input bit uca, input bit uov, input bit we, input logic [31:0] wd);
    logic [63:0] x, r;
    logic [64:0] full;
    logic [32:0] low;
    bit c_in, c64, c32, o64, o32;
    op_valid = v; op_a = a; op_b = b; op_sub = sub; op_cin = cin; op_use_ca = useca;
    mode64 = m64; upd_ca = uca; upd_ov = uov; wr_en = we; wr_data = wd;
    #1;
    c_in = useca ? m_ca : cin;
    x    = sub ? ~a : a;
    full = {1'b0, x} + {1'b0, b} + 65'(c_in);
    r    = full[63:0];
    c64  = full[64];
    low  = {1'b0, x[31:0]} + {1'b0, b[31:0]} + 33'(c_in);
    c32  = low[32];
    o64  = (x[63] == b[63]) && (r[63] != b[63]);
    o32  = (x[31] == b[31]) && (r[31] != b[31]);
    if (v) chk({tag, " R3 sum"}, sum, r);
    if (we) begin
      m_so = wd[31]; m_ov = wd[30]; m_ca = wd[29]; m_ov32 = wd[19]; m_ca32 = wd[18];
      m_cmp = wd[15:8]; m_cnt = wd[6:0];
    end else if (v) begin
      if (uca) begin m_ca = m64 ? c64 : c32; m_ca32 = c32; end
      if (uov) begin m_ov = m64 ? o64 : o32; m_ov32 = o32; m_so = m_so | m_ov; end
    end
    @(posedge clk);
    @(negedge clk);
    chk({tag, " flags"}, rd_data, model_read());
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset", rd_data, 64'd0);
    // R1 R2: all-ones write shows only the defined bits
    step("R1 R2 write ones", 0, 0, 0, 0, 0, 0, 1, 0, 0, 1, 32'hFFFF_FFFF);
    chk("R1 layout", rd_data, 64'h0000_0000_E00C_FF7F);
    // R2: single-field writes
    step("R2 only ca32", 0, 0, 0, 0, 0, 0, 1, 0, 0, 1, 32'h0004_0000);
    step("R2 so cmp", 0, 0, 0, 0, 0, 0, 1, 0, 0, 1, 32'h8000_5A00);
    // R8: write clears SO
    step("R8 clear", 0, 0, 0, 0, 0, 0, 1, 0, 0, 1, 32'h0000_0000);
    // R4: carry out of bit 63 only
    step("R4 c64", 1, 64'hFFFF_FFFF_0000_0000, 64'h0000_0001_0000_0000, 0, 0, 0, 1, 1, 1, 0, 0);
    chk("R4 ca=1 ca32=0", rd_data[29:18], 12'h800);
    // R4: carry out of bit 31 only
    step("R4 c32", 1, 64'h0000_0000_FFFF_FFFF, 64'h1, 0, 0, 0, 1, 1, 1, 0, 0);
    chk("R4 ca=0 ca32=1", rd_data[29:18], 12'h001);
    // R5: narrow mode copies low carry
    step("R5 narrow", 1, 64'h0000_0000_FFFF_FFFF, 64'h1, 0, 0, 0, 0, 1, 1, 0, 0);
    chk("R5 both carries", rd_data[29:18], 12'h801);
    // R6: full-width overflow only
    step("R6 ov64", 1, 64'h4000_0000_0000_0000, 64'h4000_0000_0000_0000, 0, 0, 0, 1, 1, 1, 0, 0);
    chk("R6 ov=1 ov32=0 so=1", {rd_data[31:30], rd_data[19]}, 3'b110);
    // R6 R8: low-word overflow only, SO stays set
    step("R6 ov32", 1, 64'h4000_0000, 64'h4000_0000, 0, 0, 0, 1, 1, 1, 0, 0);
    chk("R8 so kept", {rd_data[31:30], rd_data[19]}, 3'b101);
    // R7: narrow overflow
    step("R7 narrow", 1, 64'h7FFF_FFFF, 64'h1, 0, 0, 0, 0, 1, 1, 0, 0);
    chk("R7 ov pair", {rd_data[30], rd_data[19]}, 2'b11);
    // R3: subtract-from and extended forms
    step("R3 sub", 1, 64'd5, 64'd3, 1, 1, 0, 1, 1, 1, 0, 0);
    step("R3 sub ext", 1, 64'd3, 64'd5, 1, 0, 1, 1, 1, 1, 0, 0);
    step("R3 add ext", 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 0, 0, 1, 1, 1, 1, 0, 0);
    // R9: enables off, op would change everything
    step("R9 off", 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 0, 1, 0, 1, 0, 0, 0, 0);
    step("R9 idle", 0, 64'h8000_0000_8000_0000, 64'h8000_0000_8000_0000, 0, 0, 0, 1, 1, 1, 0, 0);
    // R10: write beats a same-cycle op
    step("R10 clash", 1, 64'h8000_0000_8000_0000, 64'h8000_0000_8000_0000, 0, 0, 0, 1, 1, 1, 1, 32'h0000_1234);
    chk("R10 write value", rd_data, 64'h0000_1234 & 64'h0000_FF7F);
    for (int i = 0; i < 400; i++) begin
      logic [63:0] ra, rb;
      int k;
      k  = $urandom_range(0, 3);
      ra = {$urandom, $urandom};
      rb = {$urandom, $urandom};
      if (k == 0) begin ra[62:0] = {63{ra[0]}}; rb[62:32] = {31{rb[1]}}; end
      if (k == 1) begin ra[30:0] = {31{ra[2]}}; rb[30:0] = {31{rb[3]}}; end
      step("R3 R4 R6 R9 R10 rand", $urandom_range(0, 4) != 0, ra, rb, $urandom_range(0, 1),
           $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1),
           $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 7) == 0, $urandom);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule